// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block tells an asynchronous DRAM access controller when a refresh is due, so that every row of a 2,048-row device is refreshed within its retention time. An interval timer counts system clocks. One tick is due per row slot: the retention time divided by the row count, at the system clock rate. Each tick adds one to a count of owed refreshes. Each refresh that the access controller grants between accesses takes one off that count. The count saturates, so the controller may defer grants for a while without losing track of the rows it owes.

Two refresh styles are chosen at run time. In the first, the controller strobes CAS before RAS and the device picks the row from its own internal counter, so the scheduler presents no address. In the second, the controller strobes RAS only, and the scheduler supplies the row from an internal counter that wraps after the last row. A period select picks the standard retention time or an extended one four times longer. The style and period inputs are taken in only while nothing is owed, so a change never skips a row.

Top module: `dram_refresh_sched`

## Requirements
- R1: A synchronous reset clears the owed count, the row counter and the interval timer, drives `req_o`, `urgent_o` and `row_addr_o` low, and selects the CAS-before-RAS style (`style_o` = 0).
- R2: With the standard period selected (`ext_sel_i` = 0), the owed count rises by one every STD_IVAL = CLK_KHZ*STD_RET_MS/ROWS clocks, with the first rise STD_IVAL clocks after reset ends.
- R3: With the extended period selected (`ext_sel_i` = 1), the spacing between rises is EXT_MULT times STD_IVAL clocks.
- R4: `req_o` is high exactly when the owed count (`debt_o`) is nonzero.
- R5: A cycle with `grant_i` high and a nonzero owed count lowers the count by one. A grant while the count is zero has no effect. A tick and an accepted grant in the same cycle leave the count unchanged.
- R6: The owed count never exceeds DEBT_MAX. A tick that arrives at DEBT_MAX is lost.
- R7: `urgent_o` is high exactly when the owed count equals DEBT_MAX.
- R8: The style input `style_sel_i` is encoded 0 = CAS-before-RAS and 1 = RAS-only. In CAS-before-RAS style `row_addr_o` is all zeros and grants do not move the row counter.
- R9: In RAS-only style `row_addr_o` shows the next row to refresh. Each accepted grant advances it by one, from ROWS-1 back to 0.
- R10: `style_sel_i` and `ext_sel_i` are captured on a clock edge only when the owed count is zero. While the count is nonzero, changes to them do not affect `style_o` or the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| style_sel_i | input | 1 | Requested refresh style: 0 CAS-before-RAS, 1 RAS-only |
| ext_sel_i | input | 1 | Requested retention period: 0 standard, 1 extended |
| grant_i | input | 1 | Access controller performs one refresh this cycle |
| req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Owed count at its limit; controller must close the page and refresh |
| debt_o | output | $clog2(DEBT_MAX+1) | Number of refreshes owed |
| style_o | output | 1 | Refresh style currently in force |
| row_addr_o | output | $clog2(ROWS) | Row for the next RAS-only refresh; zero in CAS-before-RAS style |

## Verification
The bench builds the block with CLK_KHZ = 320 and DEBT_MAX = 4, and leaves ROWS at 2,048 and EXT_MULT at 4. This makes the standard interval 5 clocks and the extended interval 20 clocks. With these values, saturation, the urgent flag and lost ticks show up within a few dozen cycles. A full 2,048-grant sweep of the 11-bit row counter, including its wrap, also fits in the run. The short interval also makes it easy to line up a tick with a grant, so the bench can cover the same-cycle cases and the timing of a configuration that is held back and applied later.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic {
      STYLE_CBR     = 1'b0,
      STYLE_RASONLY = 1'b1
   } rfsh_style_e;

   typedef struct packed {
      rfsh_style_e style;
      logic        ext;
   } rfsh_cfg_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int STD_IVAL = 1562,
   parameter int EXT_IVAL = 6248
) (
   input  logic clk,
   input  logic rst,
   input  logic ext_i,
   output logic tick_o
);

   localparam int CW = $clog2(EXT_IVAL + 1);
   localparam logic [CW-1:0] STD_LAST = CW'(STD_IVAL - 1);
   localparam logic [CW-1:0] EXT_LAST = CW'(EXT_IVAL - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;

   generate
      if (EXT_IVAL == STD_IVAL) begin : g_single
         assign last = STD_LAST;
      end else begin : g_dual
         assign last = ext_i ? EXT_LAST : STD_LAST;
      end
   endgenerate

   // >= keeps the timer sane when the limit shrinks mid-count
   assign tick_o = (cnt_q >= last);

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);

endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
   parameter int DEBT_MAX = 8,
   parameter int DEBT_W   = $clog2(DEBT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic              grant_i,
   output logic [DEBT_W-1:0] debt_o,
   output logic              take_o
);

   localparam logic [DEBT_W-1:0] LIMIT = DEBT_W'(DEBT_MAX);

   logic [DEBT_W-1:0] debt_q;
   logic              full;

   assign full   = (debt_q == LIMIT);
   assign take_o = grant_i && (debt_q != '0);
   assign debt_o = debt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         debt_q <= '0;
      end else begin
         unique case ({tick_i, take_o})
            2'b10:   if (!full) debt_q <= debt_q + 1'b1;
            2'b01:   debt_q <= debt_q - 1'b1;
            default: debt_q <= debt_q;
         endcase
      end
   end

   // R6
   debt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      debt_q <= LIMIT);
   // R2
   debt_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (tick_i && !grant_i && !full) |=> debt_q == DEBT_W'($past(debt_q) + 1'b1));
   // R5
   debt_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick_i && grant_i && debt_q != '0) |=> debt_q == DEBT_W'($past(debt_q) - 1'b1));
   // R5
   idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick_i && grant_i && debt_q == '0) |=> debt_q == '0);

endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
   parameter int ROWS     = 2048,
   parameter int ROW_BITS = $clog2(ROWS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv_i,
   output logic [ROW_BITS-1:0] row_o
);

   localparam logic [ROW_BITS-1:0] LAST = ROW_BITS'(ROWS - 1);

   logic [ROW_BITS-1:0] row_q;

   generate
      if (ROWS == (1 << ROW_BITS)) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst)        row_q <= '0;
            else if (adv_i) row_q <= row_q + 1'b1;
         end
      end else begin : g_odd
         always_ff @(posedge clk) begin
            if (rst)        row_q <= '0;
            else if (adv_i) row_q <= (row_q == LAST) ? '0 : row_q + 1'b1;
         end
      end
   endgenerate

   assign row_o = row_q;

   // R9
   row_step_chk: assert property (@(posedge clk) disable iff (rst)
      (adv_i && row_q != LAST) |=> row_q == ROW_BITS'($past(row_q) + 1'b1));
   // R9
   row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (adv_i && row_q == LAST) |=> row_q == '0);
   // R8
   row_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> $stable(row_q));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import rfsh_pkg::*;
#(
   parameter int CLK_KHZ    = 100000,
   parameter int STD_RET_MS = 32,
   parameter int EXT_MULT   = 4,
   parameter int ROWS       = 2048,
   parameter int DEBT_MAX   = 8,
   parameter int ROW_BITS   = $clog2(ROWS),
   parameter int DEBT_W     = $clog2(DEBT_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                style_sel_i,
   input  logic                ext_sel_i,
   input  logic                grant_i,
   output logic                req_o,
   output logic                urgent_o,
   output logic [DEBT_W-1:0]   debt_o,
   output logic                style_o,
   output logic [ROW_BITS-1:0] row_addr_o
);

   localparam int STD_IVAL = (CLK_KHZ * STD_RET_MS) / ROWS;
   localparam int EXT_IVAL = STD_IVAL * EXT_MULT;

   generate
      if (STD_IVAL < 2) begin : g_bad_ival
         $error("refresh interval below two clocks");
      end
      if (EXT_MULT < 1) begin : g_bad_mult
         $error("extended multiplier must be at least one");
      end
      if (DEBT_MAX < 1) begin : g_bad_debt
         $error("debt limit must be at least one");
      end
      if (ROWS < 2) begin : g_bad_rows
         $error("row count must be at least two");
      end
   endgenerate

   rfsh_cfg_t           cfg_q;
   logic                tick;
   logic                take;
   logic [DEBT_W-1:0]   debt;
   logic [ROW_BITS-1:0] row;
   logic                ras_only;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q.style <= STYLE_CBR;
         cfg_q.ext   <= 1'b0;
      end else if (debt == '0) begin
         cfg_q.style <= rfsh_style_e'(style_sel_i);
         cfg_q.ext   <= ext_sel_i;
      end
   end

   assign ras_only = (cfg_q.style == STYLE_RASONLY);

   rfsh_interval_timer #(
      .STD_IVAL (STD_IVAL),
      .EXT_IVAL (EXT_IVAL)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .ext_i  (cfg_q.ext),
      .tick_o (tick)
   );

   rfsh_debt_ctr #(
      .DEBT_MAX (DEBT_MAX),
      .DEBT_W   (DEBT_W)
   ) u_debt (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (tick),
      .grant_i (grant_i),
      .debt_o  (debt),
      .take_o  (take)
   );

   rfsh_row_ctr #(
      .ROWS     (ROWS),
      .ROW_BITS (ROW_BITS)
   ) u_row (
      .clk   (clk),
      .rst   (rst),
      .adv_i (take && ras_only),
      .row_o (row)
   );

   assign debt_o     = debt;
   assign req_o      = (debt != '0);
   assign urgent_o   = (debt == DEBT_W'(DEBT_MAX));
   assign style_o    = ras_only;
   assign row_addr_o = ras_only ? row : '0;

   // R7
   urgent_req_chk: assert property (@(posedge clk) disable iff (rst)
      urgent_o |-> req_o);
   // R10
   cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (debt != '0) |=> $stable(cfg_q));
   // R8
   cbr_addr_chk: assert property (@(posedge clk) disable iff (rst)
      !style_o |-> row_addr_o == '0);

endmodule

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;

   localparam int DMAX = 4;

   logic        clk = 1'b0;
   logic        rst;
   logic        style_sel;
   logic        ext_sel;
   logic        grant;
   logic        req;
   logic        urgent;
   logic [2:0]  debt;
   logic        style;
   logic [10:0] row_addr;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dram_refresh_sched #(
      .CLK_KHZ  (320),
      .DEBT_MAX (DMAX)
   ) dut (
      .clk         (clk),
      .rst         (rst),
      .style_sel_i (style_sel),
      .ext_sel_i   (ext_sel),
      .grant_i     (grant),
      .req_o       (req),
      .urgent_o    (urgent),
      .debt_o      (debt),
      .style_o     (style),
      .row_addr_o  (row_addr)
   );

   // fields: edges to run, grant level, expected debt, expected urgent
   localparam int VEC [11][4] = '{
      '{4, 0, 0, 0},   // R2 no tick before interval
      '{1, 0, 1, 0},   // R2 first tick
      '{5, 0, 2, 0},   // R2
      '{10, 0, 4, 1},  // R7 limit reached
      '{5, 0, 4, 1},   // R6 tick lost at limit
      '{1, 1, 3, 0},   // R5 single grant
      '{2, 1, 1, 0},   // R5
      '{1, 1, 0, 0},   // R5 drained
      '{1, 1, 1, 0},   // R5 grant at zero ignored, tick counts
      '{4, 0, 1, 0},   // R4 request held
      '{1, 1, 1, 0}    // R5 tick and grant together
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic g);
      grant = g;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run(input int n, input logic g);
      for (int i = 0; i < n; i++) step(g);
      grant = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; style_sel = 1'b0; ext_sel = 1'b0; grant = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 debt", int'(debt), 0);
      chk("R1 req", int'(req), 0);
      chk("R1 urgent", int'(urgent), 0);
      chk("R1 row", int'(row_addr), 0);
      chk("R1 style", int'(style), 0);
      rst = 1'b0;

      for (int v = 0; v < 11; v++) begin
         run(VEC[v][0], logic'(VEC[v][1]));
         chk($sformatf("R2/R5/R6 vec%0d debt", v), int'(debt), VEC[v][2]);
         chk($sformatf("R7 vec%0d urgent", v), int'(urgent), VEC[v][3]);
         chk($sformatf("R4 vec%0d req", v), int'(req), (VEC[v][2] != 0) ? 1 : 0);
         chk($sformatf("R8 vec%0d row", v), int'(row_addr), 0);
      end

      // R10: configuration held while refreshes are owed
      do_reset();
      chk("R1 debt after reset", int'(debt), 0);
      run(5, 1'b0);
      chk("R2 debt t5", int'(debt), 1);
      ext_sel = 1'b1; style_sel = 1'b1;
      run(5, 1'b0);
      chk("R10 std spacing kept", int'(debt), 2);
      chk("R10 style kept", int'(style), 0);
      run(2, 1'b1);
      chk("R5 drained", int'(debt), 0);
      run(13, 1'b0);
      chk("R3 no tick at std spacing", int'(debt), 0);
      chk("R10 style applied", int'(style), 1);
      chk("R8 CBR grants left row", int'(row_addr), 0);
      run(5, 1'b0);
      chk("R3 extended tick", int'(debt), 1);

      // R9: full sweep in RAS-only style
      ext_sel = 1'b0; style_sel = 1'b1;
      do_reset();
      run(1, 1'b0);
      chk("R9 style", int'(style), 1);
      for (int k = 1; k <= 2051; k++) begin
         while (!req) step(1'b0);
         step(1'b1);
         grant = 1'b0;
         chk($sformatf("R9 row after grant %0d", k), int'(row_addr), k % 2048);
      end

      // R1: reset mid-run clears row and debt
      run(5, 1'b0);
      do_reset();
      chk("R1 row cleared", int'(row_addr), 0);
      chk("R1 debt cleared", int'(debt), 0);
      chk("R1 urgent cleared", int'(urgent), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule